// File: doc/BRIEF.md
# Interleaved Dual-Bank Burst Read Sequencer

This block serves unbroken burst reads out of two word-wide storage banks. One bank holds the even word addresses and the other holds the odd ones. Each bank has its own index counter. A load cycle sets both counters from a start address. Each later read cycle then takes one word from the bank whose turn it is, steps that bank's counter, and hands the turn to the other bank. A burst has no length limit: counters wrap at the top of a bank. A burst can be paused by deselecting the block and resumed later at the word where it stopped.

Every access happens on a clock edge where the read strobe is high and the active-low select is low. The registered word, a data-valid flag, a bank flag and an output-enable flag all appear one clock after that edge. A small write port fills the banks for test. Its writes are dropped in any cycle that is also an access. Bank depth is `2**IDX_W` words. The default `IDX_W` is 10. Setting `IDX_W` to 15 gives 32K-word banks.

Top module: `burst_read_seq`

## Requirements
- R1: After reset, `dout_oe` and `dout_valid` are 0, both counters are 0 and the turn points at the even bank, so the first plain read returns even word 0 and the next returns odd word 0.
- R2: A load (access with `ale`=1) whose `addr[0]`=0 outputs even word `addr[IDX_W:1]`, then odd word `addr[IDX_W:1]`, then even word `addr[IDX_W:1]`+1.
- R3: A load whose `addr[0]`=1 outputs odd word `addr[IDX_W:1]`, then even word `addr[IDX_W:1]`+1, then odd word `addr[IDX_W:1]`+1.
- R4: Each plain access (`ale`=0) reads the bank whose turn it is, steps only that bank's counter, and passes the turn to the other bank.
- R5: Word, `dout_valid`=1 and `dout_odd` (1 = odd bank, 0 = even bank) are registered and appear one clock after the access edge.
- R6: With `cs_n`=1, `dout_oe` drops to 0 one clock later and no access occurs whatever `rd_stb` and `ale` do. The counters and the turn hold, and a later plain access resumes the burst with the next word in sequence.
- R7: When selection returns with `ale`=1 on an access, a new load replaces the paused position.
- R8: A counter at index `2**IDX_W-1` wraps to 0 when stepped, and the burst continues across the wrap.
- R9: A load in the middle of a burst replaces both counters and the turn at once.
- R10: An edge with `cs_n`=0 and `rd_stb`=0 performs no access: `dout_valid` is 0 one clock later, `dout_oe` stays 1, `dout_odd` holds, and `ale` is ignored.
- R11: With `wr_en`=1, `wr_data` is stored at index `wr_idx` of the bank chosen by `wr_bank` (0 = even). The write is dropped if the same edge is an access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; high means standby |
| ale | input | 1 | Address-load strobe, qualified by an access |
| rd_stb | input | 1 | Read strobe; one access per edge when selected |
| addr | input | IDX_W+1 | Start word address; bit 0 picks the starting bank |
| wr_en | input | 1 | Preload write enable |
| wr_bank | input | 1 | Preload bank, 0 even, 1 odd |
| wr_idx | input | IDX_W | Preload word index within the bank |
| wr_data | input | DATA_W | Preload data |
| dout | output | DATA_W | Word read by the last access |
| dout_oe | output | 1 | Output drive enable; 0 means high impedance |
| dout_valid | output | 1 | High for one clock after each access |
| dout_odd | output | 1 | Bank that supplied `dout`, 1 = odd |

## Verification
Two events can land on the same edge: a preload write and a read access. They can even target the same word. The bench provokes this by issuing a load of even word 50 while writing a different value to that very word. It then judges the outcome by the word the load returns and by a second load of the same address, which must still show the preloaded value. A write issued in the idle cycle just after must appear on the next turn of that bank.

// File: rtl/brs_pkg.sv
package brs_pkg;

    typedef enum logic {
        BANK_EVEN = 1'b0,
        BANK_ODD  = 1'b1
    } bank_e;

endpackage

// File: rtl/brs_bank.sv
module brs_bank #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic              re,
    input  logic [IDX_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // synchronous write and enabled synchronous read; read word holds between reads
    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[widx] <= wdata;
        end
        if (re) begin
            rdata <= mem_q[ridx];
        end
    end

endmodule

// File: rtl/brs_seq.sv
module brs_seq
    import brs_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic             load,
    input  logic             cs_n,
    input  logic             a0,
    input  logic [IDX_W-1:0] aidx,
    output logic             re_even,
    output logic             re_odd,
    output logic [IDX_W-1:0] ridx_even,
    output logic [IDX_W-1:0] ridx_odd,
    output logic             sel_odd,
    output logic             valid,
    output logic             oe
);
    typedef struct packed {
        logic [IDX_W-1:0] even_cnt;
        logic [IDX_W-1:0] odd_cnt;
        bank_e            turn;
        bank_e            sel;
        logic             valid;
        logic             oe;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.valid = acc;
        st_d.oe    = ~cs_n;
        re_even    = 1'b0;
        re_odd     = 1'b0;
        ridx_even  = st_q.even_cnt;
        ridx_odd   = st_q.odd_cnt;

        if (acc) begin
            if (load) begin
                if (!a0) begin
                    // even word first: even counter moves past it, odd waits on same index
                    re_even       = 1'b1;
                    ridx_even     = aidx;
                    st_d.even_cnt = aidx + 1'b1;
                    st_d.odd_cnt  = aidx;
                    st_d.turn     = BANK_ODD;
                    st_d.sel      = BANK_EVEN;
                end else begin
                    // odd word first: next even word lives one index higher
                    re_odd        = 1'b1;
                    ridx_odd      = aidx;
                    st_d.odd_cnt  = aidx + 1'b1;
                    st_d.even_cnt = aidx + 1'b1;
                    st_d.turn     = BANK_EVEN;
                    st_d.sel      = BANK_ODD;
                end
            end else if (st_q.turn == BANK_ODD) begin
                re_odd       = 1'b1;
                st_d.odd_cnt = st_q.odd_cnt + 1'b1;
                st_d.turn    = BANK_EVEN;
                st_d.sel     = BANK_ODD;
            end else begin
                re_even       = 1'b1;
                st_d.even_cnt = st_q.even_cnt + 1'b1;
                st_d.turn     = BANK_ODD;
                st_d.sel      = BANK_EVEN;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{even_cnt: '0, odd_cnt: '0, turn: BANK_EVEN,
                      sel: BANK_EVEN, valid: 1'b0, oe: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_odd = (st_q.sel == BANK_ODD);
    assign valid   = st_q.valid;
    assign oe      = st_q.oe;

endmodule

// File: rtl/burst_read_seq.sv
module burst_read_seq #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ale,
    input  logic              rd_stb,
    input  logic [IDX_W:0]    addr,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              dout_valid,
    output logic              dout_odd
);
    localparam int NBANK = 2;

    logic                acc;
    logic                load;
    logic [NBANK-1:0]    re;
    logic [NBANK-1:0]    we;
    logic [IDX_W-1:0]    ridx  [NBANK];
    logic [DATA_W-1:0]   rdata [NBANK];

    assign acc  = rd_stb & ~cs_n;
    assign load = acc & ale;

    brs_seq #(.IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .load      (load),
        .cs_n      (cs_n),
        .a0        (addr[0]),
        .aidx      (addr[IDX_W:1]),
        .re_even   (re[0]),
        .re_odd    (re[1]),
        .ridx_even (ridx[0]),
        .ridx_odd  (ridx[1]),
        .sel_odd   (dout_odd),
        .valid     (dout_valid),
        .oe        (dout_oe)
    );

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        // preload yields to any access on the same edge
        assign we[g] = wr_en & ~acc & (wr_bank == 1'(g));

        brs_bank #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_bank (
            .clk   (clk),
            .we    (we[g]),
            .widx  (wr_idx),
            .wdata (wr_data),
            .re    (re[g]),
            .ridx  (ridx[g]),
            .rdata (rdata[g])
        );
    end

    assign dout = rdata[dout_odd];

endmodule

// File: rtl/brs_checker.sv
module brs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic ale,
    input logic rd_stb,
    input logic addr0,
    input logic dout_oe,
    input logic dout_valid,
    input logic dout_odd
);
    logic acc;
    logic seen_q;

    assign acc = rd_stb & ~cs_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
        end else if (acc) begin
            seen_q <= 1'b1;
        end
    end

    assert_valid_after_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> dout_valid);

    assert_no_valid_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> !dout_valid);

    assert_bank_held_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !acc |=> $stable(dout_odd));

    assert_standby_hiz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> !dout_oe);

    assert_drive_when_selected_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |=> dout_oe);

    assert_even_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ale && !addr0) |=> !dout_odd);

    assert_odd_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && ale && addr0) |=> dout_odd);

    assert_alternate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !ale && seen_q) |=> (dout_odd != $past(dout_odd)));

endmodule

bind burst_read_seq brs_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .ale        (ale),
    .rd_stb     (rd_stb),
    .addr0      (addr[0]),
    .dout_oe    (dout_oe),
    .dout_valid (dout_valid),
    .dout_odd   (dout_odd)
);

// File: tb/tb_burst_read_seq.sv
module tb_burst_read_seq;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 10;
    localparam int DATA_W     = 16;
    localparam int NROW       = 25;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              ale = 1'b0;
    logic              rd_stb = 1'b0;
    logic [IDX_W:0]    addr = '0;
    logic              wr_en = 1'b0;
    logic              wr_bank = 1'b0;
    logic [IDX_W-1:0]  wr_idx = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] dout;
    logic              dout_oe;
    logic              dout_valid;
    logic              dout_odd;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_read_seq #(.IDX_W(IDX_W), .DATA_W(DATA_W)) dut (.*);

    // row: {ale, cs_n, rd_stb, addr[10:0], exp_valid, exp_oe, exp_odd, exp_idx[9:0]}
    localparam logic [26:0] TBL [NROW] = '{
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd0   },  // R1 even 0
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd0   },  // R1 odd 0
        {1'b0,1'b0,1'b0,11'h000, 1'b0,1'b1,1'b1,10'd0   },  // R10 idle
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd1   },  // R4 even 1
        {1'b1,1'b0,1'b1,11'h00A, 1'b1,1'b1,1'b0,10'd5   },  // R2 load even 5
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd5   },  // R2 odd 5
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd6   },  // R4 even 6
        {1'b0,1'b1,1'b1,11'h000, 1'b0,1'b0,1'b0,10'd0   },  // R6 standby
        {1'b1,1'b1,1'b0,11'h3FF, 1'b0,1'b0,1'b0,10'd0   },  // R6 standby, ale ignored
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd6   },  // R6 resume odd 6
        {1'b1,1'b0,1'b1,11'h013, 1'b1,1'b1,1'b1,10'd9   },  // R3 load odd 9
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd10  },  // R3 even 10
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd10  },  // R4 odd 10
        {1'b0,1'b1,1'b1,11'h000, 1'b0,1'b0,1'b0,10'd0   },  // R6 standby
        {1'b1,1'b0,1'b1,11'h021, 1'b1,1'b1,1'b1,10'd16  },  // R7 reload odd 16
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd17  },  // R7 even 17
        {1'b1,1'b0,1'b1,11'h7FE, 1'b1,1'b1,1'b0,10'd1023},  // R9 interrupt even 1023
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd1023},  // R8 odd 1023
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd0   },  // R8 even wrapped
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd0   },  // R8 odd wrapped
        {1'b1,1'b0,1'b1,11'h7FF, 1'b1,1'b1,1'b1,10'd1023},  // R8 load odd 1023
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd0   },  // R8 even 1024 wraps
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b1,10'd0   },  // R8 odd wrapped
        {1'b1,1'b0,1'b0,11'h000, 1'b0,1'b1,1'b1,10'd0   },  // R10 ale without strobe
        {1'b0,1'b0,1'b1,11'h000, 1'b1,1'b1,1'b0,10'd1   }   // R10 sequence kept
    };

    function automatic string row_tag(input int i);
        case (i)
            0, 1:              return "R1";
            2, 23, 24:         return "R10";
            4, 5:              return "R2";
            10, 11:            return "R3";
            7, 8, 9, 13:       return "R6";
            14, 15:            return "R7";
            16:                return "R9";
            17, 18, 19, 20, 21, 22: return "R8";
            default:           return "R4";
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] pre_word(input logic odd, input int idx);
        return (odd ? 16'h8000 : 16'h4000) + 16'(idx);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [DATA_W-1:0] got, input logic [DATA_W-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // drive at a negedge, let one posedge pass, return at the next negedge
    task automatic cyc(input logic a, input logic c, input logic r, input logic [IDX_W:0] ad);
        ale = a; cs_n = c; rd_stb = r; addr = ad;
        @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired before the run ended (all requirements)");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "oe after reset", 16'(dout_oe), 16'd0);
        chk("R1", "valid after reset", 16'(dout_valid), 16'd0);

        // preload both banks (R11)
        cs_n = 1'b1;
        for (int b = 0; b < 2; b++) begin
            for (int i = 0; i < (1 << IDX_W); i++) begin
                wr_en = 1'b1; wr_bank = b[0]; wr_idx = i[IDX_W-1:0];
                wr_data = pre_word(b[0], i);
                @(negedge clk);
            end
        end
        wr_en = 1'b0;

        for (int i = 0; i < NROW; i++) begin
            logic [26:0] row;
            row = TBL[i];
            cyc(row[26], row[25], row[24], row[23:13]);
            chk("R5", $sformatf("row %0d valid", i), 16'(dout_valid), 16'(row[12]));
            chk("R6", $sformatf("row %0d oe", i), 16'(dout_oe), 16'(row[11]));
            if (row[12]) begin
                chk(row_tag(i), $sformatf("row %0d bank", i), 16'(dout_odd), 16'(row[10]));
                chk(row_tag(i), $sformatf("row %0d data", i), dout,
                    pre_word(row[10], int'(row[9:0])));
            end
        end

        // R11: write colliding with a load of the same word is dropped
        wr_en = 1'b1; wr_bank = 1'b0; wr_idx = 10'd50; wr_data = 16'hDEAD;
        cyc(1'b1, 1'b0, 1'b1, 11'd100);
        wr_en = 1'b0;
        chk("R11", "load during write", dout, pre_word(1'b0, 50));
        cyc(1'b0, 1'b0, 1'b1, 11'd0);
        chk("R11", "odd 50", dout, pre_word(1'b1, 50));
        wr_en = 1'b1; wr_bank = 1'b0; wr_idx = 10'd51; wr_data = 16'hBEEF;
        cyc(1'b0, 1'b0, 1'b0, 11'd0);
        wr_en = 1'b0;
        cyc(1'b0, 1'b0, 1'b1, 11'd0);
        chk("R11", "idle write stored", dout, 16'hBEEF);
        chk("R11", "bank of stored word", 16'(dout_odd), 16'd0);
        cyc(1'b1, 1'b0, 1'b1, 11'd100);
        chk("R11", "collided word unchanged", dout, pre_word(1'b0, 50));

        // R1: reset in mid burst restores counters and turn
        cyc(1'b0, 1'b0, 1'b1, 11'd0);
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 1'b0, 11'd0);
        chk("R1", "oe in reset", 16'(dout_oe), 16'd0);
        chk("R1", "valid in reset", 16'(dout_valid), 16'd0);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 1'b1, 11'd0);
        chk("R1", "first word after reset", dout, pre_word(1'b0, 0));
        chk("R1", "first bank after reset", 16'(dout_odd), 16'd0);
        cyc(1'b0, 1'b0, 1'b1, 11'd0);
        chk("R1", "second word after reset", dout, pre_word(1'b1, 0));

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule